// File: doc/BRIEF.md
# Load Issue Gate with Blocked-Load Tracking

This block sits between the load execute lanes and the data cache. Each cycle up to `LANES` executing loads arrive at once, lane 0 taking precedence. For each load the gate decides one of four things: it goes to the cache, it is sent back to be rescheduled, it raises a machine-check fault, or it is caught by a cache that is busy or refuses it. Loads that bypass the cache (uncacheable) may only go ahead when they sit at the load-queue head and are also at commit. Only `PORTS` cache ports exist per cycle. The count of ports in use starts again from zero every cycle.

When the cache is busy, or refuses a request for any reason other than a bad address, the gate keeps one blocked-load record. The record holds the sequence number of the oldest such load, which is the smallest number. A separate handled flag goes with it. Outside logic clears the blocked flag with one strobe and sets the handled flag with another. A refusal that is not a bad address also raises a retry request and latches the requesting thread id.

The cache request side works as a one-cycle valid/ready offer. `mem_valid[i]` is asserted for a single cycle and `mem_ready[i]` (with `mem_bad[i]`) is sampled in that same cycle. The gate never holds an offer across cycles. A refused offer becomes a fault, or a retry and a blocked record, and the load leaves the gate.

Top module: `load_issue_gate`

## Requirements
- R1: A valid load with `ld_unc`=1 whose index differs from `lq_head`, or whose `ld_commit`=0, gets `ld_resched`=1 and `ld_fault`=1. It gets `mem_valid`=0 and uses no port.
- R2: A valid uncacheable load that is both at `lq_head` and at commit is treated exactly like a cacheable load.
- R3: Lanes claim ports in order from lane 0 upward. A valid load that passes R1 claims a port only while fewer than `PORTS` ports have been claimed this cycle. Otherwise it gets `ld_resched`=1 with no fault. `used_ports` equals the number of ports claimed this cycle and never exceeds `PORTS`.
- R4: A load that claims a port while `cache_busy`=1 uses the port and gets `mem_valid`=0. It becomes a blocked candidate.
- R5: An offered load (`mem_valid`=1) refused (`mem_ready`=0) with `mem_bad`=1 gets `ld_fault`=1. It causes neither a retry nor a blocked candidate.
- R6: An offered load refused with `mem_bad`=0 raises `retry_req` that cycle and becomes a blocked candidate. From the next cycle, `retry_tid` holds the `thread_id` of that cycle.
- R7: Among this cycle's blocked candidates the smallest sequence number is chosen. It is written to `blk_seq`, with `blk_flag`=1 on the next cycle, unless `blk_flag` is already 1 and the stored `blk_seq` is strictly smaller.
- R8: Writing a record clears `blk_handled`. Otherwise `hnd_set` sets `blk_handled` and `blk_clr` clears `blk_flag`. A record write wins over both strobes in the same cycle.
- R9: Reset clears `blk_flag`, `blk_handled`, `blk_seq` and `retry_tid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_vld | input | LANES | Load present on lane |
| ld_unc | input | LANES | Load is uncacheable |
| ld_commit | input | LANES | Load is at commit |
| ld_idx | input | LANES*IDXW | Load-queue index per lane |
| ld_seq | input | LANES*SEQW | Sequence number per lane |
| lq_head | input | IDXW | Load-queue head index |
| thread_id | input | TIDW | Thread issuing this cycle |
| cache_busy | input | 1 | Cache cannot accept anything this cycle |
| mem_valid | output | LANES | Request offered to cache |
| mem_ready | input | LANES | Cache accepts offer |
| mem_bad | input | LANES | Refusal is a bad address |
| ld_resched | output | LANES | Load must be rescheduled |
| ld_fault | output | LANES | Machine-check fault for load |
| used_ports | output | CNTW | Ports claimed this cycle |
| retry_req | output | 1 | A refusal asks for a retry |
| retry_tid | output | TIDW | Thread latched for retry |
| blk_clr | input | 1 | Strobe: clear blocked flag |
| hnd_set | input | 1 | Strobe: mark blocked load handled |
| blk_flag | output | 1 | A blocked load is recorded |
| blk_handled | output | 1 | Recorded load has been handled |
| blk_seq | output | SEQW | Sequence number of the recorded load |

## Verification
The bench sweeps every combination of lane presence, uncacheable, at-commit, head match, per-lane ready and bad-address, cache busy and both strobes. Sequence numbers and thread ids are varied along the way. With one port and two lanes, the sweep separates a denial for ordering (R1) from a denial for port exhaustion (R3). Both lanes wanting a port shows that lane 1 loses only when lane 0 actually claimed. The ready/bad/busy patterns distinguish a bad-address fault from a retry and from a busy block. Running the record model across consecutive cycles shows oldest-wins replacement, ties, and strobe priority.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

  typedef struct packed {
    logic wants;    // passed ordering rule, asks for a port
    logic issue;    // offered to the cache
    logic resched;  // sent back for rescheduling
    logic fault;    // machine-check indication
    logic retry;    // refused, not bad address
    logic blocked;  // blocked-record candidate
  } lane_res_t;

endpackage

// File: rtl/lsg_lane.sv
module lsg_lane #(
  parameter int IDXW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vld,
  input  logic                   unc,
  input  logic                   at_commit,
  input  logic [IDXW-1:0]        idx,
  input  logic [IDXW-1:0]        head,
  input  logic                   port_ok,
  input  logic                   busy,
  input  logic                   mem_ready,
  input  logic                   mem_bad,
  output lsg_pkg::lane_res_t     res
);

  logic unc_bad;
  logic claim;
  logic refused;

  always_comb begin
    unc_bad     = vld && unc && ((idx != head) || !at_commit);
    res.wants   = vld && !unc_bad;
    claim       = res.wants && port_ok;
    res.issue   = claim && !busy;
    refused     = res.issue && !mem_ready;
    res.fault   = unc_bad || (refused && mem_bad);
    res.retry   = refused && !mem_bad;
    res.blocked = (claim && busy) || res.retry;
    res.resched = unc_bad || (res.wants && !port_ok);
  end

  assert_unc_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && unc && (idx != head)) |-> (res.resched && res.fault && !res.issue));

  assert_bad_no_retry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res.issue && !mem_ready && mem_bad) |-> (res.fault && !res.retry && !res.blocked));

  assert_busy_no_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !res.issue);

endmodule

// File: rtl/lsg_blk_rec.sv
module lsg_blk_rec #(
  parameter int LANES = 2,
  parameter int SEQW  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      cand,
  input  logic [LANES*SEQW-1:0] cand_seq,
  input  logic                  clr,
  input  logic                  hset,
  output logic                  flag,
  output logic                  handled,
  output logic [SEQW-1:0]       seq
);

  logic [LANES:0]  bv;
  logic [SEQW-1:0] bs [LANES+1];
  logic            rec;

  assign bv[0] = 1'b0;
  assign bs[0] = '0;

  for (genvar i = 0; i < LANES; i++) begin : g_min
    logic [SEQW-1:0] s;
    logic            take;
    assign s        = cand_seq[i*SEQW +: SEQW];
    assign take     = cand[i] && (!bv[i] || (s < bs[i]));
    assign bv[i+1]  = bv[i] || cand[i];
    assign bs[i+1]  = take ? s : bs[i];
  end

  assign rec = bv[LANES] && !(flag && (seq < bs[LANES]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      handled <= 1'b0;
      seq     <= '0;
    end else if (rec) begin
      flag    <= 1'b1;
      handled <= 1'b0;
      seq     <= bs[LANES];
    end else begin
      if (clr)  flag    <= 1'b0;
      if (hset) handled <= 1'b1;
    end
  end

  assert_rec_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec |=> (flag && !handled));

  assert_keep_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !rec) |=> $stable(seq));

  assert_hset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hset && !rec) |=> handled);

endmodule

// File: rtl/load_issue_gate.sv
module load_issue_gate #(
  parameter int LANES = 2,
  parameter int PORTS = 1,
  parameter int IDXW  = 3,
  parameter int SEQW  = 8,
  parameter int TIDW  = 2,
  localparam int CNTW = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      ld_vld,
  input  logic [LANES-1:0]      ld_unc,
  input  logic [LANES-1:0]      ld_commit,
  input  logic [LANES*IDXW-1:0] ld_idx,
  input  logic [LANES*SEQW-1:0] ld_seq,
  input  logic [IDXW-1:0]       lq_head,
  input  logic [TIDW-1:0]       thread_id,
  input  logic                  cache_busy,
  output logic [LANES-1:0]      mem_valid,
  input  logic [LANES-1:0]      mem_ready,
  input  logic [LANES-1:0]      mem_bad,
  output logic [LANES-1:0]      ld_resched,
  output logic [LANES-1:0]      ld_fault,
  output logic [CNTW-1:0]       used_ports,
  output logic                  retry_req,
  output logic [TIDW-1:0]       retry_tid,
  input  logic                  blk_clr,
  input  logic                  hnd_set,
  output logic                  blk_flag,
  output logic                  blk_handled,
  output logic [SEQW-1:0]       blk_seq
);

  lsg_pkg::lane_res_t res [LANES];
  logic [CNTW-1:0]    taken [LANES+1];
  logic [LANES-1:0]   port_ok;
  logic [LANES-1:0]   retry_v;
  logic [LANES-1:0]   blk_v;

  assign taken[0] = '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign port_ok[i] = int'(taken[i]) < PORTS;
    assign taken[i+1] = taken[i] + CNTW'(res[i].wants && port_ok[i]);

    lsg_lane #(.IDXW(IDXW)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .vld       (ld_vld[i]),
      .unc       (ld_unc[i]),
      .at_commit (ld_commit[i]),
      .idx       (ld_idx[i*IDXW +: IDXW]),
      .head      (lq_head),
      .port_ok   (port_ok[i]),
      .busy      (cache_busy),
      .mem_ready (mem_ready[i]),
      .mem_bad   (mem_bad[i]),
      .res       (res[i])
    );

    assign mem_valid[i]  = res[i].issue;
    assign ld_resched[i] = res[i].resched;
    assign ld_fault[i]   = res[i].fault;
    assign retry_v[i]    = res[i].retry;
    assign blk_v[i]      = res[i].blocked;
  end

  assign used_ports = taken[LANES];
  assign retry_req  = |retry_v;

  always_ff @(posedge clk) begin
    if (!rst_n)         retry_tid <= '0;
    else if (retry_req) retry_tid <= thread_id;
  end

  lsg_blk_rec #(.LANES(LANES), .SEQW(SEQW)) u_rec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand     (blk_v),
    .cand_seq (ld_seq),
    .clr      (blk_clr),
    .hset     (hnd_set),
    .flag     (blk_flag),
    .handled  (blk_handled),
    .seq      (blk_seq)
  );

  assert_port_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used_ports) <= PORTS);

  assert_retry_tid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |=> (retry_tid == $past(thread_id)));

endmodule

// File: tb/tb_load_issue_gate.sv
`timescale 1ns/1ps
module tb_load_issue_gate;

  localparam int LANES = 2, PORTS = 1, IDXW = 3, SEQW = 8, TIDW = 2;
  localparam int CNTW = $clog2(LANES + 1);

  logic clk = 0;
  always #5 clk = ~clk;

  logic                  rst_n;
  logic [LANES-1:0]      ld_vld, ld_unc, ld_commit, mem_ready, mem_bad;
  logic [LANES*IDXW-1:0] ld_idx;
  logic [LANES*SEQW-1:0] ld_seq;
  logic [IDXW-1:0]       lq_head;
  logic [TIDW-1:0]       thread_id;
  logic                  cache_busy, blk_clr, hnd_set;
  logic [LANES-1:0]      mem_valid, ld_resched, ld_fault;
  logic [CNTW-1:0]       used_ports;
  logic                  retry_req, blk_flag, blk_handled;
  logic [TIDW-1:0]       retry_tid;
  logic [SEQW-1:0]       blk_seq;

  load_issue_gate #(.LANES(LANES), .PORTS(PORTS), .IDXW(IDXW), .SEQW(SEQW), .TIDW(TIDW)) dut (
    .clk(clk), .rst_n(rst_n), .ld_vld(ld_vld), .ld_unc(ld_unc), .ld_commit(ld_commit),
    .ld_idx(ld_idx), .ld_seq(ld_seq), .lq_head(lq_head), .thread_id(thread_id),
    .cache_busy(cache_busy), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_bad(mem_bad),
    .ld_resched(ld_resched), .ld_fault(ld_fault), .used_ports(used_ports),
    .retry_req(retry_req), .retry_tid(retry_tid), .blk_clr(blk_clr), .hnd_set(hnd_set),
    .blk_flag(blk_flag), .blk_handled(blk_handled), .blk_seq(blk_seq));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      if (n_fail < 30) $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // model state
  int m_flag = 0, m_hnd = 0, m_seq = 0, m_tid = 0;

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ld_vld = 0; ld_unc = 0; ld_commit = 0; mem_ready = 0; mem_bad = 0;
    ld_idx = 0; ld_seq = 0; lq_head = 0; thread_id = 0; cache_busy = 0;
    blk_clr = 0; hnd_set = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9 blk_flag", int'(blk_flag), 0);
    chk("R9 blk_handled", int'(blk_handled), 0);
    chk("R9 blk_seq", int'(blk_seq), 0);
    chk("R9 retry_tid", int'(retry_tid), 0);
    chk("R9 used_ports", int'(used_ports), 0);
    rst_n = 1;

    for (int n = 0; n < 32768; n++) begin
      int used, cand_v, cand_s, any_retry;
      int e_iss [LANES], e_rs [LANES], e_ft [LANES];
      int seqs [LANES];
      logic [14:0] b;
      b = 15'(n);
      lq_head   = 3'((n * 5) % 8);
      thread_id = 2'((n >> 2) % 4);
      seqs[0]   = (n * 37) % 256;
      seqs[1]   = (n * 91 + 13) % 256;
      if ((n % 97) == 0) seqs[1] = seqs[0];
      for (int i = 0; i < LANES; i++) begin
        ld_vld[i]    = b[i*4+0];
        ld_unc[i]    = b[i*4+1];
        ld_commit[i] = b[i*4+2];
        ld_idx[i*IDXW +: IDXW] = b[i*4+3] ? lq_head : lq_head + 3'd1;
        ld_seq[i*SEQW +: SEQW] = 8'(seqs[i]);
        mem_ready[i] = b[8 + i*2];
        mem_bad[i]   = b[9 + i*2];
      end
      cache_busy = b[12];
      blk_clr    = b[13];
      hnd_set    = b[14];

      // expected (R1..R6)
      used = 0; cand_v = 0; cand_s = 0; any_retry = 0;
      for (int i = 0; i < LANES; i++) begin
        int blk;
        e_iss[i] = 0; e_rs[i] = 0; e_ft[i] = 0; blk = 0;
        if (b[i*4+0]) begin
          if (b[i*4+1] && !(b[i*4+3] && b[i*4+2])) begin   // R1 (else R2: at head and commit)
            e_rs[i] = 1; e_ft[i] = 1;
          end else if (used >= PORTS) begin                // R3
            e_rs[i] = 1;
          end else begin
            used++;
            if (cache_busy) blk = 1;                       // R4
            else begin
              e_iss[i] = 1;
              if (!b[8+i*2]) begin
                if (b[9+i*2]) e_ft[i] = 1;                 // R5
                else begin any_retry = 1; blk = 1; end     // R6
              end
            end
          end
        end
        if (blk && (!cand_v || seqs[i] < cand_s)) begin cand_v = 1; cand_s = seqs[i]; end
      end

      #1;
      for (int i = 0; i < LANES; i++) begin
        chk("R1 R2 R3 R4 mem_valid", int'(mem_valid[i]), e_iss[i]);
        chk("R1 R3 ld_resched", int'(ld_resched[i]), e_rs[i]);
        chk("R1 R5 ld_fault", int'(ld_fault[i]), e_ft[i]);
      end
      chk("R3 used_ports", int'(used_ports), used);
      chk("R6 retry_req", int'(retry_req), any_retry);

      @(posedge clk);
      // model update R6 R7 R8
      if (any_retry) m_tid = (n >> 2) % 4;
      if (cand_v && !(m_flag && m_seq < cand_s)) begin
        m_flag = 1; m_hnd = 0; m_seq = cand_s;
      end else begin
        if (b[13]) m_flag = 0;
        if (b[14]) m_hnd = 1;
      end
      #1;
      chk("R6 retry_tid", int'(retry_tid), m_tid);
      chk("R7 R8 blk_flag", int'(blk_flag), m_flag);
      chk("R8 blk_handled", int'(blk_handled), m_hnd);
      chk("R7 blk_seq", int'(blk_seq), m_seq);
      @(negedge clk);
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule